// File: doc/BRIEF.md
# Lane-Partitioned SIMD Binary Adder

This block adds two 64-bit operands either as a single wide word or as several narrower packed lanes: two of 32 bits, four of 16 bits or eight of 8 bits. A two-bit partition command picks the lane width on every cycle, so a datapath can change its packing between consecutive operations without any reconfiguration step. Only the lowest lane receives the external carry-in. Every lane reports its own carry-out on an eight-bit carry vector, with one bit per byte.

The carry chain is made of ten carry-select blocks whose widths grow from the least significant end: 1, 3, 4, 5, 6, 7, 8, 9, 10 and 11 bits. Each bit cell recodes its operands into an AND term and an OR term, and the incoming carry selects between them. Each block also has a skip path. When every bit of the block propagates, the skip path passes the block's carry-in straight to its carry-out. Lane boundaries fall at byte positions inside these blocks, so each block that holds a boundary decodes the partition command for itself and forces the carry to zero at that bit when the boundary is active. The sum and the carry vector are registered, which gives a latency of one cycle.

Top module: `lane_split_adder`

## Requirements
- R1: When `rst` is high at a rising clock edge, `sum_q` and `lane_co_q` become zero at that edge.
- R2: The outputs after each rising edge reflect the inputs sampled at that edge, so the latency is exactly one cycle, back-to-back operations are allowed and the mode may change on every cycle.
- R3: With `part0`=1 and `part1`=1 (64-bit mode), `{lane_co_q[7], sum_q}` equals `op_a + op_b + carry_in`.
- R4: With `part0`=0 and `part1`=1 (32-bit mode), bits 31:0 hold the sum of the low halves plus `carry_in`, with the carry on `lane_co_q[3]`. Bits 63:32 hold the sum of the high halves with carry-in 0, with the carry on `lane_co_q[7]`.
- R5: With `part0`=1 and `part1`=0 (16-bit mode), each 16-bit lane j (bits 16j+15:16j) holds its own modulo-2^16 sum, with the carry on `lane_co_q[2j+1]`. Only lane 0 adds `carry_in`.
- R6: With `part0`=0 and `part1`=0 (8-bit mode), each byte lane j holds its own modulo-256 sum, with the carry on `lane_co_q[j]`. Only lane 0 adds `carry_in`.
- R7: No carry crosses an active lane boundary. An all-ones operand plus `carry_in` changes only lane 0.
- R8: A bit of `lane_co_q` whose byte is not the top byte of a lane reads 0.
- R9: Across a boundary that the mode leaves inactive, the carry propagates through every block. This includes a ripple through the whole 64 bits when all bits propagate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| part0 | input | 1 | Partition command, low bit |
| part1 | input | 1 | Partition command, high bit |
| op_a | input | 64 | First operand, packed lanes |
| op_b | input | 64 | Second operand, packed lanes |
| carry_in | input | 1 | Carry into lane 0 |
| sum_q | output | 64 | Registered packed sum |
| lane_co_q | output | 8 | Registered carry-out per byte position |

## Verification
A boundary that is wrongly cut or wrongly left open shows up at the ports in the very next cycle. An open boundary lets a carry leak from one lane into the lowest bit of the lane above it. A wrongly cut boundary drops the carry inside a lane, and the lane carry that should have reported it stays low. A faulty skip select or a wrong block offset corrupts only the operands whose propagate pattern covers a whole block. For that reason the all-ones ripple cases and random operands in every mode are checked one cycle after they are applied, against a per-lane reference sum.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int DATA_W   = 64;
  localparam int BYTE_W   = 8;
  localparam int NUM_BYTE = DATA_W / BYTE_W;
  localparam int NUM_BLK  = 10;

  // block widths grow linearly: 1, 3, 4, 5 ... 11
  function automatic int blk_width(input int n);
    return (n == 0) ? 1 : n + 2;
  endfunction

  function automatic int blk_base(input int n);
    int acc;
    acc = 0;
    for (int j = 0; j < n; j++) acc += blk_width(j);
    return acc;
  endfunction

  // byte boundary index held inside block n (0: none)
  function automatic int blk_cut_idx(input int n);
    int pos;
    for (int i = 0; i < blk_width(n); i++) begin
      pos = blk_base(n) + i;
      if ((pos % BYTE_W == 0) && (pos != 0)) return pos / BYTE_W;
    end
    return 0;
  endfunction

  function automatic int blk_cut_ofs(input int n);
    int pos;
    for (int i = 0; i < blk_width(n); i++) begin
      pos = blk_base(n) + i;
      if ((pos % BYTE_W == 0) && (pos != 0)) return i;
    end
    return 0;
  endfunction
endpackage

// File: rtl/lsa_cut_decode.sv
module lsa_cut_decode #(
  parameter int NUM_BYTE = 8
) (
  input  logic                  part0,
  input  logic                  part1,
  output logic [NUM_BYTE-1:1]   cut_o
);
  localparam int HALF = NUM_BYTE / 2;
  localparam int QUAR = NUM_BYTE / 4;

  for (genvar k = 1; k < NUM_BYTE; k++) begin : g_bnd
    if (k % HALF == 0) begin : g_w32
      assign cut_o[k] = ~(part0 & part1);
    end else if (k % QUAR == 0) begin : g_w16
      assign cut_o[k] = ~part1;
    end else begin : g_w8
      assign cut_o[k] = ~part0 & ~part1;
    end
  end
endmodule

// File: rtl/lsa_bit_cell.sv
module lsa_bit_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o,
  output logic p_o
);
  logic both, either;
  assign both   = a_i & b_i;
  assign either = a_i | b_i;
  assign p_o    = a_i ^ b_i;
  assign s_o    = p_o ^ c_i;
  assign c_o    = c_i ? either : both;
endmodule

// File: rtl/lsa_skip_block.sv
module lsa_skip_block #(
  parameter int W       = 4,
  parameter bit HAS_CUT = 1'b0,
  parameter int CUT_OFS = 0,
  localparam int NOUT   = HAS_CUT ? 2 : 1
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic            cin_i,
  input  logic            cut_i,
  output logic [W-1:0]    s_o,
  output logic [NOUT-1:0] cy_o
);
  logic [W-1:0] prev_c, ci, co, prop;
  logic         skip;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_first
      assign prev_c[i] = cin_i;
    end else begin : g_next
      assign prev_c[i] = co[i-1];
    end
    if (HAS_CUT && (i == CUT_OFS)) begin : g_cut
      assign ci[i] = cut_i ? 1'b0 : prev_c[i];
    end else begin : g_pass
      assign ci[i] = prev_c[i];
    end
    lsa_bit_cell u_cell (
      .a_i(a_i[i]), .b_i(b_i[i]), .c_i(ci[i]),
      .s_o(s_o[i]), .c_o(co[i]), .p_o(prop[i])
    );
  end

  assign skip    = &prop;
  assign cy_o[0] = (skip & ~cut_i) ? cin_i : co[W-1];

  if (HAS_CUT) begin : g_tap
    assign cy_o[NOUT-1] = prev_c[CUT_OFS];
  end
endmodule

// File: rtl/lane_split_adder.sv
module lane_split_adder
  import lsa_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                part0,
  input  logic                part1,
  input  logic [DATA_W-1:0]   op_a,
  input  logic [DATA_W-1:0]   op_b,
  input  logic                carry_in,
  output logic [DATA_W-1:0]   sum_q,
  output logic [NUM_BYTE-1:0] lane_co_q
);
  logic [NUM_BYTE-1:1] cut_vec;
  logic [NUM_BLK:0]    blk_c;
  logic [DATA_W-1:0]   sum_d;
  logic [NUM_BYTE-1:0] byte_co, lane_end;

  lsa_cut_decode #(.NUM_BYTE(NUM_BYTE)) u_dec (
    .part0(part0), .part1(part1), .cut_o(cut_vec)
  );

  assign blk_c[0] = carry_in;

  for (genvar n = 0; n < NUM_BLK; n++) begin : g_blk
    localparam int W  = blk_width(n);
    localparam int B  = blk_base(n);
    localparam int K  = blk_cut_idx(n);
    localparam int O  = blk_cut_ofs(n);
    localparam bit HC = (K != 0);
    localparam int NO = HC ? 2 : 1;
    logic          cut_sel;
    logic [NO-1:0] cy;

    if (HC) begin : g_c
      assign cut_sel    = cut_vec[K];
      assign byte_co[K-1] = cy[NO-1];
    end else begin : g_n
      assign cut_sel = 1'b0;
    end

    lsa_skip_block #(.W(W), .HAS_CUT(HC), .CUT_OFS(O)) u_blk (
      .a_i(op_a[B +: W]), .b_i(op_b[B +: W]), .cin_i(blk_c[n]),
      .cut_i(cut_sel), .s_o(sum_d[B +: W]), .cy_o(cy)
    );
    assign blk_c[n+1] = cy[0];
  end

  assign byte_co[NUM_BYTE-1] = blk_c[NUM_BLK];

  for (genvar k = 0; k < NUM_BYTE; k++) begin : g_end
    if (k == NUM_BYTE - 1) begin : g_top
      assign lane_end[k] = 1'b1;
    end else begin : g_mid
      assign lane_end[k] = cut_vec[k+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q     <= '0;
      lane_co_q <= '0;
    end else begin
      sum_q     <= sum_d;
      lane_co_q <= byte_co & lane_end;
    end
  end
endmodule

// File: rtl/lane_split_adder_chk.sv
module lane_split_adder_chk (
  input logic        clk,
  input logic        rst,
  input logic        part0,
  input logic        part1,
  input logic [63:0] op_a,
  input logic [63:0] op_b,
  input logic        carry_in,
  input logic [63:0] sum_q,
  input logic [7:0]  lane_co_q
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (sum_q == 64'd0 && lane_co_q == 8'd0));

  // R3, R2
  a_r3_full_width: assert property (@(posedge clk) disable iff (rst)
    (part0 && part1) |=> ({lane_co_q[7], sum_q} ==
      ({1'b0, $past(op_a)} + {1'b0, $past(op_b)} + {64'd0, $past(carry_in)})));

  // R4
  a_r4_low_half: assert property (@(posedge clk) disable iff (rst)
    (!part0 && part1) |=> ({lane_co_q[3], sum_q[31:0]} ==
      ({1'b0, $past(op_a[31:0])} + {1'b0, $past(op_b[31:0])} + {32'd0, $past(carry_in)})));

  // R6, R7
  a_r6_byte3_isolated: assert property (@(posedge clk) disable iff (rst)
    (!part0 && !part1) |=> ({lane_co_q[3], sum_q[31:24]} ==
      ({1'b0, $past(op_a[31:24])} + {1'b0, $past(op_b[31:24])})));

  // R8
  a_r8_no_inner_carry: assert property (@(posedge clk) disable iff (rst)
    (part0 && part1) |=> (lane_co_q[6:0] == 7'd0));

  // R8
  a_r8_even_bytes_16: assert property (@(posedge clk) disable iff (rst)
    (part0 && !part1) |=> ({lane_co_q[6], lane_co_q[4], lane_co_q[2], lane_co_q[0]} == 4'd0));
endmodule

bind lane_split_adder lane_split_adder_chk chk_i (
  .clk(clk), .rst(rst), .part0(part0), .part1(part1),
  .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
  .sum_q(sum_q), .lane_co_q(lane_co_q)
);

// File: tb/lane_split_adder_tb_top.sv
`timescale 1ns/1ps
module lane_split_adder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        part0 = 1'b0, part1 = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic        carry_in = 1'b0;
  logic [63:0] sum_q;
  logic [7:0]  lane_co_q;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] sum;
    logic [7:0]  co;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  lane_split_adder dut_i (
    .clk(clk), .rst(rst), .part0(part0), .part1(part1),
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sum_q(sum_q), .lane_co_q(lane_co_q)
  );

  function automatic exp_t ref_calc(bit p0, bit p1, logic [63:0] a, logic [63:0] b,
                                    bit ci, string tag);
    exp_t e;
    int lw;
    logic [64:0] x, y, s, m;
    lw = (p0 && p1) ? 64 : (p1 ? 32 : (p0 ? 16 : 8));
    m  = (65'd1 << lw) - 65'd1;
    e.sum = '0; e.co = '0; e.tag = tag;
    for (int l = 0; l < 64 / lw; l++) begin
      x = ({1'b0, a} >> (l * lw)) & m;
      y = ({1'b0, b} >> (l * lw)) & m;
      s = x + y + ((l == 0 && ci) ? 65'd1 : 65'd0);
      e.sum = e.sum | (s[63:0] & m[63:0]) << (l * lw);
      e.co[(l + 1) * lw / 8 - 1] = s[lw];
    end
    return e;
  endfunction

  task automatic drive(bit p0, bit p1, logic [63:0] a, logic [63:0] b, bit ci, string tag);
    @(negedge clk);
    part0 = p0; part1 = p1; op_a = a; op_b = b; carry_in = ci;
    sb.push_back(ref_calc(p0, p1, a, b, ci, tag));
  endtask

  // monitor: one expected item per edge, sampled away from the edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (sum_q !== e.sum || lane_co_q !== e.co) begin
        n_fail++;
        $display("FAIL %s: sum=%h co=%b expected sum=%h co=%b",
                 e.tag, sum_q, lane_co_q, e.sum, e.co);
      end
    end
  end

  task automatic check_reset(string when);
    n_chk++;
    if (sum_q !== 64'd0 || lane_co_q !== 8'd0) begin
      n_fail++;
      $display("FAIL R1 (%s): sum=%h co=%b expected sum=0 co=0", when, sum_q, lane_co_q);
    end
  endtask

  initial begin : watchdog
    #400000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] ra, rb;
    // R1 at start-up with busy inputs
    part0 = 1; part1 = 1; op_a = '1; op_b = 64'h1234; carry_in = 1;
    repeat (2) @(posedge clk);
    #1 check_reset("start");
    @(negedge clk) rst = 0;

    // R9: full ripple through all blocks
    drive(1, 1, '1, 64'd0, 1, "R9 ripple64");
    drive(1, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 1, "R9 ripple63");
    drive(1, 0, 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0000, 0, "R9 16bit");
    // R7: carries never cross active boundaries
    drive(0, 0, '1, 64'd0, 1, "R7 byte wall");
    drive(0, 1, 64'h0000_0000_FFFF_FFFF, 64'd0, 1, "R7 half wall");
    drive(1, 0, '1, 64'd0, 1, "R7 16bit wall");
    // R8: inner carry bits are masked
    drive(1, 0, '1, '1, 1, "R8 16bit masks");
    drive(0, 1, '1, '1, 0, "R8 32bit masks");
    drive(1, 1, '1, '1, 1, "R8 64bit masks");
    // R2: mode changes every cycle
    drive(0, 0, 64'h8080_8080_8080_8080, 64'h8080_8080_8080_8080, 0, "R2 b2b");
    drive(1, 1, 64'h8080_8080_8080_8080, 64'h8080_8080_8080_8080, 0, "R2 b2b");
    drive(0, 1, 64'h8000_0000_8000_0000, 64'h8000_0000_8000_0000, 1, "R2 b2b");
    drive(1, 0, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 1, "R2 b2b");

    for (int i = 0; i < 120; i++) begin
      ra = {$urandom, $urandom}; rb = {$urandom, $urandom};
      drive(1, 1, ra, rb, i[0], "R3 random 64");
      ra = {$urandom, $urandom}; rb = {$urandom, $urandom};
      drive(0, 1, ra, rb, i[1], "R4 random 32");
      ra = {$urandom, $urandom}; rb = {$urandom, $urandom};
      drive(1, 0, ra, rb, i[0], "R5 random 16");
      ra = {$urandom, $urandom}; rb = {$urandom, $urandom};
      drive(0, 0, ra, rb, i[1], "R6 random 8");
    end

    @(negedge clk);
    @(negedge clk);
    // R1 mid-run with nonzero outputs
    drive(1, 1, '1, 64'd5, 0, "R3 pre-reset");
    @(negedge clk);
    rst = 1;
    @(posedge clk);
    #1 check_reset("mid-run");
    @(negedge clk) rst = 0;
    drive(0, 0, 64'h0102_0304_0506_0708, 64'hFF00_FF00_FF00_FF00, 1, "R6 after reset");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule